// File: doc/BRIEF.md
# Programmable Chip Select Unit

This block sits beside a 32-bit bus master. It compares every bus cycle against four programmable decode channels. The comparison uses the byte address, a 3-bit address-space code and the read/write direction. When a channel claims the cycle, the block pulls that channel's active-low select line. It then ends the cycle with an internally generated, active-low data-size acknowledge. That acknowledge reports the width of the attached port and appears after a programmed number of wait states, or in the very first cycle when fast termination is chosen.

Software sets up each channel through a simple write-only register bus. Each channel has one base word and one mask word. Together they give the channel:

- its address window, a power-of-two size from 256 bytes to the full 4 GB;
- an address-space filter;
- write protection;
- its port width and acknowledge timing.

Straight out of reset a boot mode is active. In this mode channel 0 answers every cycle, so code can be fetched from a boot device before any channel is set up. The mode ends for good on the first write to channel 0's base word.

Top module: `chip_select_unit`

## Requirements
- R1: A register write with `reg_wr_en` high stores `reg_wdata` at the next clock edge. `reg_addr[0]` selects the word: 0 is the base word, 1 is the mask word. `reg_addr[2:1]` selects the channel. Base word bits [31:8] hold the window start. Address bits [7:0] never take part in the compare.
- R2: Mask word bits [31:8] mark address bits that are ignored in the compare. Set bits there open a power-of-two window above a base aligned to that size. An address just outside the window does not match.
- R3: Base word bit 7 is the enable bit. A channel whose enable bit is clear never asserts its select.
- R4: Base word bit 6 is write protection. When it is set, a write cycle (`bus_write`=1) into the window does not select the channel, while a read cycle does.
- R5: Base word bits [2:0] are compared with `bus_fc`. Mask word bits [2:0] mark code bits that are ignored.
- R6: Mask word bits [7:6] give the port width, and the acknowledge code follows it. 2'b01 is an 8-bit port, returning `dsack_n`=2'b10. 2'b10 is a 16-bit port, returning 2'b01. 2'b00 and 2'b11 are a 32-bit port, returning 2'b00.
- R7: The timing code is {base bit 5, mask bits [5:4]}. Values 0 to 6 insert that many wait states: `dsack_n` first becomes active in strobe cycle N+1, counting the first cycle with `bus_strobe` high as cycle 0. It then stays active while the strobe is held.
- R8: Timing code 3'b111 selects fast termination, so `dsack_n` is active already in strobe cycle 0.
- R9: After reset, channel 0 selects every cycle, whatever its address, code and direction. It uses channel 0's register values for port width and timing, which are 32-bit and zero wait states after reset. This lasts until the first write to channel 0's base word.
- R10: When no channel matches, all `cs_n` bits and both `dsack_n` bits stay high.
- R11: When several channels match, only the lowest-numbered one is selected, and the acknowledge uses that channel's width and timing.
- R12: While `bus_strobe` is low, and in reset, `cs_n` is all ones and `dsack_n` is 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | {channel, word select} |
| reg_wdata | input | 32 | Register write data |
| bus_strobe | input | 1 | High for the whole of a bus cycle |
| bus_addr | input | 32 | Bus byte address |
| bus_fc | input | 3 | Address-space code |
| bus_write | input | 1 | 1 = write cycle |
| cs_n | output | 4 | Active-low channel selects |
| dsack_n | output | 2 | Active-low data-size acknowledge |

## Verification
The assertions check several rules on every cycle:

- at most one select is low at a time;
- nothing is driven while the strobe is low;
- an acknowledge never appears without a select;
- channel 0 is selected whenever boot mode is active, and boot mode never returns once it has ended;
- a fast-termination winner acknowledges in the first strobe cycle.

Window sizes, enable and protection bits, code masking, the width encoding, and the exact cycle of the acknowledge for each wait count depend on the programmed values. Only the bench's directed scenarios can show those.

// File: rtl/cs_unit_pkg.sv
package cs_unit_pkg;
  localparam int ADDR_W  = 32;
  localparam int PAGE_W  = 8;                 // bits never compared
  localparam int WIN_W   = ADDR_W - PAGE_W;   // compared address bits
  localparam int FC_W    = 3;
  localparam int TMO_W   = 3;
  localparam int CNT_W   = 3;
  localparam logic [TMO_W-1:0] TMO_FAST = '1;

  typedef enum logic [1:0] {
    PW_32A = 2'b00,
    PW_8   = 2'b01,
    PW_16  = 2'b10,
    PW_32B = 2'b11
  } port_w_e;

  typedef struct packed {
    logic [WIN_W-1:0] start;
    logic             enable;
    logic             wprot;
    logic             tmo_hi;
    logic [1:0]       spare;
    logic [FC_W-1:0]  fc;
  } base_word_t;

  typedef struct packed {
    logic [WIN_W-1:0] ignore;
    port_w_e          width;
    logic [1:0]       tmo_lo;
    logic             spare;
    logic [FC_W-1:0]  fc_ignore;
  } mask_word_t;

  // address window compare on the upper bits only
  function automatic logic window_hit(input logic [ADDR_W-1:0] a,
                                      input logic [WIN_W-1:0] start,
                                      input logic [WIN_W-1:0] ignore);
    return ((a[ADDR_W-1:PAGE_W] ^ start) & ~ignore) == '0;
  endfunction

  function automatic logic space_hit(input logic [FC_W-1:0] code,
                                     input logic [FC_W-1:0] want,
                                     input logic [FC_W-1:0] ignore);
    return ((code ^ want) & ~ignore) == '0;
  endfunction

  // active-low acknowledge code for a port width
  function automatic logic [1:0] ack_code(input port_w_e w);
    case (w)
      PW_8:    return 2'b10;
      PW_16:   return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  // ready once the strobe-cycle count passes the wait count
  function automatic logic ack_ready(input logic [TMO_W-1:0] tmo,
                                     input logic [CNT_W-1:0] cnt);
    return (tmo == TMO_FAST) || (cnt > CNT_W'(tmo));
  endfunction
endpackage

// File: rtl/cs_channel.sv
module cs_channel
  import cs_unit_pkg::*;
(
  input  base_word_t         base_w,
  input  mask_word_t         mask_w,
  input  logic               force_hit,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [FC_W-1:0]    fc,
  input  logic               wr,
  output logic               hit,
  output logic [TMO_W-1:0]   tmo,
  output port_w_e            width
);
  logic addr_ok, fc_ok, wr_ok;

  always_comb begin
    addr_ok = window_hit(addr, base_w.start, mask_w.ignore);
    fc_ok   = space_hit(fc, base_w.fc, mask_w.fc_ignore);
    wr_ok   = !(base_w.wprot && wr);
    hit     = force_hit || (base_w.enable && addr_ok && fc_ok && wr_ok);
    tmo     = {base_w.tmo_hi, mask_w.tmo_lo};
    width   = mask_w.width;
  end
endmodule

// File: rtl/cs_priority.sv
module cs_priority #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  always_comb begin
    logic taken;
    taken = 1'b0;
    gnt   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !taken) begin
        gnt[i] = 1'b1;
        taken  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cs_wait_counter.sv
module cs_wait_counter
  import cs_unit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!strobe)      cnt <= '0;
    else if (cnt != '1)    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/chip_select_unit.sv
module chip_select_unit
  import cs_unit_pkg::*;
#(
  parameter int NCH  = 4,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int RA_W = CH_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  input  logic              bus_strobe,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [FC_W-1:0]   bus_fc,
  input  logic              bus_write,
  output logic [NCH-1:0]    cs_n,
  output logic [1:0]        dsack_n
);
  base_word_t base_q [NCH];
  mask_word_t mask_q [NCH];
  logic       boot_q;

  logic [CH_W-1:0] wr_ch;
  logic            wr_mask;
  assign wr_ch   = reg_addr[RA_W-1:1];
  assign wr_mask = reg_addr[0];

  // register file and boot-mode flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        base_q[i] <= '0;
        mask_q[i] <= '0;
      end
      boot_q <= 1'b1;
    end else if (reg_wr_en) begin
      for (int i = 0; i < NCH; i++) begin
        if (wr_ch == CH_W'(i)) begin
          if (wr_mask) mask_q[i] <= mask_word_t'(reg_wdata);
          else         base_q[i] <= base_word_t'(reg_wdata);
        end
      end
      if (!wr_mask && wr_ch == '0) boot_q <= 1'b0;
    end
  end

  // per-channel decode
  logic [NCH-1:0]   ch_hit;
  logic [TMO_W-1:0] ch_tmo   [NCH];
  port_w_e          ch_width [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic force_w;
    if (g == 0) begin : g_boot
      assign force_w = boot_q;
    end else begin : g_noboot
      assign force_w = 1'b0;
    end
    cs_channel u_ch (
      .base_w    (base_q[g]),
      .mask_w    (mask_q[g]),
      .force_hit (force_w),
      .addr      (bus_addr),
      .fc        (bus_fc),
      .wr        (bus_write),
      .hit       (ch_hit[g]),
      .tmo       (ch_tmo[g]),
      .width     (ch_width[g])
    );
  end

  logic [NCH-1:0] grant;
  cs_priority #(.N(NCH)) u_prio (.req(ch_hit), .gnt(grant));

  logic [CNT_W-1:0] cnt_q;
  cs_wait_counter u_cnt (.clk(clk), .rst_n(rst_n), .strobe(bus_strobe), .cnt(cnt_q));

  // winner's timing and width, named for the checker
  logic [TMO_W-1:0] win_tmo;
  port_w_e          win_width;
  logic             any_hit, win_fast, ack_now;

  always_comb begin
    win_tmo   = '0;
    win_width = PW_32A;
    for (int i = 0; i < NCH; i++) begin
      if (grant[i]) begin
        win_tmo   = ch_tmo[i];
        win_width = ch_width[i];
      end
    end
    any_hit  = |ch_hit;
    win_fast = (win_tmo == TMO_FAST);
    ack_now  = bus_strobe && any_hit && ack_ready(win_tmo, cnt_q);
  end

  assign cs_n    = ~(grant & {NCH{bus_strobe}});
  assign dsack_n = ack_now ? ack_code(win_width) : 2'b11;
endmodule

// File: rtl/cs_unit_checker.sv
module cs_unit_checker
  import cs_unit_pkg::*;
#(
  parameter int NCH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_strobe,
  input logic [NCH-1:0]   cs_n,
  input logic [1:0]       dsack_n,
  input logic             boot_active,
  input logic             fast_sel,
  input logic             any_hit,
  input logic [CNT_W-1:0] wait_cnt
);
  assert_one_select_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_strobe |-> (cs_n == '1 && dsack_n == 2'b11));

  assert_ack_needs_select_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dsack_n != 2'b11) |-> (cs_n != '1));

  assert_boot_channel0_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_active && bus_strobe) |-> !cs_n[0]);

  assert_boot_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_active |=> !boot_active);

  assert_fast_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && any_hit && fast_sel && wait_cnt == '0) |-> (dsack_n != 2'b11));
endmodule

bind chip_select_unit cs_unit_checker #(.NCH(NCH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_strobe  (bus_strobe),
  .cs_n        (cs_n),
  .dsack_n     (dsack_n),
  .boot_active (boot_q),
  .fast_sel    (win_fast),
  .any_hit     (any_hit),
  .wait_cnt    (cnt_q)
);

// File: tb/sim_chip_select_unit.sv
`timescale 1ns/1ps
module sim_chip_select_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        bus_strobe = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [2:0]  bus_fc = '0;
  logic        bus_write = 1'b0;
  logic [3:0]  cs_n;
  logic [1:0]  dsack_n;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  chip_select_unit u0 (.*);

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_base(input logic [23:0] s, input bit en,
      input bit wp, input bit thi, input logic [2:0] fc);
    return {s, en, wp, thi, 2'b00, fc};
  endfunction

  function automatic logic [31:0] mk_mask(input logic [23:0] ig, input logic [1:0] pw,
      input logic [1:0] tlo, input logic [2:0] fcm);
    return {ig, pw, tlo, 1'b0, fcm};
  endfunction

  task automatic wr_reg(input int ch, input bit is_mask, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1;
    reg_addr  = {ch[1:0], is_mask};
    reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  // one bus cycle; cs sampled in strobe cycle 0, first acknowledge cycle recorded
  task automatic access(input logic [31:0] a, input logic [2:0] fc, input logic wr,
                        output logic [3:0] cs_seen, output logic [1:0] ds_seen,
                        output int ds_at);
    @(negedge clk);
    bus_addr = a; bus_fc = fc; bus_write = wr; bus_strobe = 1'b1;
    ds_at = -1; ds_seen = 2'b11; cs_seen = 4'hF;
    for (int k = 0; k < 10; k++) begin
      #1;
      if (k == 0) cs_seen = cs_n;
      if (ds_at < 0 && dsack_n != 2'b11) begin
        ds_at = k; ds_seen = dsack_n;
      end
      @(negedge clk);
    end
    bus_strobe = 1'b0;
    @(negedge clk);
  endtask

  logic [3:0] cs_v;
  logic [1:0] ds_v;
  int         at_v;

  task automatic t_reset;
    #1;
    chk("R12", "cs_n in reset", cs_n, 4'hF);
    chk("R12", "dsack_n in reset", dsack_n, 2'b11);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R12", "cs_n idle", cs_n, 4'hF);
    chk("R12", "dsack_n idle", dsack_n, 2'b11);
  endtask

  task automatic t_boot;
    access(32'hDEAD_BE00, 3'd5, 1'b1, cs_v, ds_v, at_v);
    chk("R9", "boot cs_n", cs_v, 4'b1110);
    chk("R9", "boot dsack", ds_v, 2'b00);
    chk("R9", "boot ack cycle", at_v, 1);
    wr_reg(0, 1'b1, mk_mask(24'h00000F, 2'b00, 2'b00, 3'b111));
    access(32'h7000_0000, 3'd2, 1'b0, cs_v, ds_v, at_v);
    chk("R9", "boot kept after mask write", cs_v, 4'b1110);
    wr_reg(0, 1'b0, mk_base(24'h000000, 1'b1, 1'b0, 1'b0, 3'd0));
    access(32'hDEAD_BE00, 3'd5, 1'b1, cs_v, ds_v, at_v);
    chk("R10", "no match cs_n", cs_v, 4'hF);
    chk("R10", "no match dsack", ds_v, 2'b11);
  endtask

  task automatic t_window;
    access(32'h0000_0FFF, 3'd3, 1'b0, cs_v, ds_v, at_v);
    chk("R2", "top of 4KB window", cs_v, 4'b1110);
    access(32'h0000_00A7, 3'd0, 1'b0, cs_v, ds_v, at_v);
    chk("R1", "low byte bits ignored", cs_v, 4'b1110);
    access(32'h0000_1000, 3'd0, 1'b0, cs_v, ds_v, at_v);
    chk("R2", "just past window", cs_v, 4'hF);
  endtask

  task automatic t_valid_wp;
    wr_reg(1, 1'b1, mk_mask(24'h0, 2'b00, 2'b00, 3'b111));
    wr_reg(1, 1'b0, mk_base(24'h100000, 1'b0, 1'b0, 1'b0, 3'd0));
    access(32'h1000_0010, 3'd0, 1'b0, cs_v, ds_v, at_v);
    chk("R3", "disabled channel", cs_v, 4'hF);
    wr_reg(1, 1'b0, mk_base(24'h100000, 1'b1, 1'b0, 1'b0, 3'd0));
    access(32'h1000_0010, 3'd0, 1'b0, cs_v, ds_v, at_v);
    chk("R3", "enabled channel", cs_v, 4'b1101);
    chk("R1", "exact 256B page on ch1", ds_v, 2'b00);
    access(32'h1000_0110, 3'd0, 1'b0, cs_v, ds_v, at_v);
    chk("R1", "next page misses", cs_v, 4'hF);
    wr_reg(1, 1'b0, mk_base(24'h100000, 1'b1, 1'b1, 1'b0, 3'd0));
    access(32'h1000_0010, 3'd0, 1'b0, cs_v, ds_v, at_v);
    chk("R4", "protected read", cs_v, 4'b1101);
    access(32'h1000_0010, 3'd0, 1'b1, cs_v, ds_v, at_v);
    chk("R4", "protected write cs_n", cs_v, 4'hF);
    chk("R4", "protected write dsack", ds_v, 2'b11);
  endtask

  task automatic t_space_width;
    wr_reg(2, 1'b0, mk_base(24'h200000, 1'b1, 1'b0, 1'b0, 3'd5));
    wr_reg(2, 1'b1, mk_mask(24'h0, 2'b01, 2'b00, 3'b000));
    access(32'h2000_0000, 3'd5, 1'b0, cs_v, ds_v, at_v);
    chk("R5", "code match", cs_v, 4'b1011);
    chk("R6", "8-bit ack", ds_v, 2'b10);
    access(32'h2000_0000, 3'd1, 1'b0, cs_v, ds_v, at_v);
    chk("R5", "code mismatch", cs_v, 4'hF);
    wr_reg(2, 1'b1, mk_mask(24'h0, 2'b10, 2'b00, 3'b010));
    access(32'h2000_0000, 3'd7, 1'b0, cs_v, ds_v, at_v);
    chk("R5", "masked code bit", cs_v, 4'b1011);
    chk("R6", "16-bit ack", ds_v, 2'b01);
    access(32'h2000_0000, 3'd4, 1'b0, cs_v, ds_v, at_v);
    chk("R5", "unmasked code bit", cs_v, 4'hF);
    wr_reg(2, 1'b1, mk_mask(24'h0, 2'b11, 2'b00, 3'b000));
    access(32'h2000_0000, 3'd5, 1'b0, cs_v, ds_v, at_v);
    chk("R6", "32-bit ack (code 11)", ds_v, 2'b00);
  endtask

  task automatic t_waits;
    wr_reg(3, 1'b1, mk_mask(24'h0000FF, 2'b00, 2'b00, 3'b111));
    for (int ws = 0; ws < 7; ws++) begin
      logic [2:0] t;
      t = 3'(ws);
      wr_reg(3, 1'b0, mk_base(24'h300000, 1'b1, 1'b0, t[2], 3'd0));
      wr_reg(3, 1'b1, mk_mask(24'h0000FF, 2'b00, t[1:0], 3'b111));
      access(32'h3000_F000, 3'd0, 1'b0, cs_v, ds_v, at_v);
      chk("R7", $sformatf("ack cycle for %0d waits", ws), at_v, ws + 1);
    end
    wr_reg(3, 1'b0, mk_base(24'h300000, 1'b1, 1'b0, 1'b1, 3'd0));
    wr_reg(3, 1'b1, mk_mask(24'h0000FF, 2'b10, 2'b11, 3'b111));
    access(32'h3000_F000, 3'd0, 1'b0, cs_v, ds_v, at_v);
    chk("R8", "fast ack cycle", at_v, 0);
    chk("R8", "fast ack code", ds_v, 2'b01);
  endtask

  task automatic t_priority;
    wr_reg(1, 1'b0, mk_base(24'h300000, 1'b1, 1'b0, 1'b0, 3'd0));
    wr_reg(1, 1'b1, mk_mask(24'h0, 2'b01, 2'b10, 3'b111));
    access(32'h3000_0040, 3'd0, 1'b0, cs_v, ds_v, at_v);
    chk("R11", "lower channel wins", cs_v, 4'b1101);
    chk("R11", "winner width", ds_v, 2'b10);
    chk("R11", "winner timing", at_v, 3);
    access(32'h3000_0140, 3'd0, 1'b0, cs_v, ds_v, at_v);
    chk("R11", "only ch3 matches", cs_v, 4'b0111);
  endtask

  initial begin
    t_reset();
    t_boot();
    t_window();
    t_valid_wp();
    t_space_width();
    t_waits();
    t_priority();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule